// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synthesizable model of a synchronous static memory with a 64-bit word, eight byte lanes and a parameterized depth. Every control and data input is taken at the rising clock edge. An address strobe loads a base address and starts a burst. Advance cycles then step a 2-bit beat counter through a group of four words, in either linear or interleaved order. A global write stores the whole word. Per-lane write enables store only the selected bytes. A cycle with no write enable active is a read.

Read data goes through a pipeline register and appears on the data output after the clock edge that follows the capturing edge. The output driver enable is gated by an asynchronous active-low output enable. Three chip enables, sampled with the strobe, allow several devices to share one address space. A strobe that sees any of them inactive puts the device into a deselected state, in which it neither drives nor writes.

Top module: `sbsram_top`

## Requirements
- R1: After reset, dq_oe_o is 0 and dq_o is 0.
- R2: A read cycle, meaning a selected cycle with gwr_n_i high and every bwe_n_i bit high, puts the addressed word on dq_o after the next rising edge. dq_oe_o is high at that time if oe_n_i is low.
- R3: With ord_i = 0 (linear), each advance beat after a strobe to base address B accesses B with its low two bits set to (B[1:0] + count) mod 4. The upper address bits do not change, so the sequence wraps within the aligned group of four.
- R4: With ord_i = 1 (interleaved), each beat's low two address bits are B[1:0] XOR count. A burst starting at low bits 11 accesses 11, 10, 01, 00.
- R5: A selected cycle with strb_n_i high and adv_n_i high keeps the beat counter unchanged and accesses the same word again.
- R6: A strobe (strb_n_i low) loads the base and clears the counter even when adv_n_i is also low.
- R7: With gwr_n_i high, byte lane n (data bits 8n+7..8n) is written exactly when bwe_n_i[n] is low. Other lanes keep their contents.
- R8: With gwr_n_i low, all eight lanes are written whatever bwe_n_i holds.
- R9: A selected cycle with gwr_n_i high and bwe_n_i all ones changes no memory contents and is served as a read.
- R10: A strobe while cs_a_n_i is high, cs_b_i is low or cs_c_n_i is high deselects the device. Until the next selecting strobe, no word is written, advance is ignored, and dq_oe_o stays low from the following edge on.
- R11: oe_n_i acts without a clock. While it is high, dq_oe_o is 0 and dq_o keeps its value. When it returns low, dq_oe_o rises again for pending read data.
- R12: After a write cycle, dq_oe_o is low on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address, loaded on a strobe |
| strb_n_i | input | 1 | Address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| cs_a_n_i | input | 1 | Chip enable, active low |
| cs_b_i | input | 1 | Chip enable, active high |
| cs_c_n_i | input | 1 | Chip enable, active low |
| gwr_n_i | input | 1 | Global write of all lanes, active low |
| bwe_n_i | input | 8 | Per-lane write enables, active low |
| ord_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata_i | input | 64 | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_o | output | 64 | Registered read data |
| dq_oe_o | output | 1 | Output driver enable; low means high impedance |

## Verification
A corrupted beat counter or base register shows on dq_o as a word from a neighbouring address. A check catches it one edge after the first affected access, because every word holds distinct random data. A lost select flag either raises dq_oe_o during a deselected stretch or lets a write land that later reads back wrong. A wrong lane mask shows as single mismatched bytes on the next read of that word. The bench fills the whole memory first, so every read has a known expected value.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_ord_e;

    typedef struct packed {
        logic              valid;
        logic [LANES-1:0]  lane_we;
        logic [WORD_W-1:0] wdata;
    } acc_ctl_t;

    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input burst_ord_e ord);
        if (ord == ORD_INTERLEAVE) return start ^ cnt;
        return start + cnt;
    endfunction

endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          strb_n_i,
    input  logic          adv_n_i,
    input  logic          chip_on_i,
    input  burst_ord_e    ord_i,
    output logic          acc_valid_o,
    output logic [AW-1:0] acc_addr_o
);

    logic          sel_q,  sel_d;
    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q,  cnt_d;

    always_comb begin
        sel_d  = sel_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        if (!strb_n_i) begin
            sel_d = chip_on_i;
            if (chip_on_i) begin
                base_d = addr_i;
                cnt_d  = 2'd0;
            end
        end else if (!adv_n_i && sel_q) begin
            cnt_d = cnt_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else begin
            sel_q  <= sel_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    assign acc_valid_o = sel_d;
    assign acc_addr_o  = {base_d[AW-1:2], beat_low(base_d[1:0], cnt_d, ord_i)};

    // R3: an advance on a selected device steps the counter by one
    a_r3_advance_step: assert property (@(posedge clk) disable iff (rst)
        (sel_q && strb_n_i && !adv_n_i) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R5: no strobe and no advance leaves the burst position alone
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (strb_n_i && adv_n_i) |=> ($stable(cnt_q) && $stable(base_q)));

    // R6: a selecting strobe restarts the counter even with advance low
    a_r6_strobe_restart: assert property (@(posedge clk) disable iff (rst)
        (!strb_n_i && chip_on_i) |=> (cnt_q == 2'd0 && sel_q));

    // R10: a strobe with a chip enable inactive deselects
    a_r10_deselect: assert property (@(posedge clk) disable iff (rst)
        (!strb_n_i && !chip_on_i) |=> !sel_q);

endmodule

// File: rtl/sbsram_lanes.sv
module sbsram_lanes
    import sbsram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_i,
    input  logic [LANES-1:0]  lane_we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_i && lane_we_i[g])
                mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_i,
    input  logic              strb_n_i,
    input  logic              adv_n_i,
    input  logic              cs_a_n_i,
    input  logic              cs_b_i,
    input  logic              cs_c_n_i,
    input  logic              gwr_n_i,
    input  logic [7:0]        bwe_n_i,
    input  logic              ord_i,
    input  logic [63:0]       wdata_i,
    input  logic              oe_n_i,
    output logic [63:0]       dq_o,
    output logic              dq_oe_o
);

    logic          chip_on;
    logic          acc_valid;
    logic [AW-1:0] acc_addr;
    logic [LANES-1:0] lane_we;
    burst_ord_e    ord;

    acc_ctl_t          s1_q;
    logic [AW-1:0]     s1_addr_q;
    logic              s1_wr, s1_rd;
    logic [WORD_W-1:0] rdata;
    logic [WORD_W-1:0] dout_q;
    logic              drv_q;

    assign chip_on = !cs_a_n_i && cs_b_i && !cs_c_n_i;
    assign lane_we = !gwr_n_i ? {LANES{1'b1}} : ~bwe_n_i;
    assign ord     = burst_ord_e'(ord_i);

    sbsram_burst #(.AW(AW)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .strb_n_i   (strb_n_i),
        .adv_n_i    (adv_n_i),
        .chip_on_i  (chip_on),
        .ord_i      (ord),
        .acc_valid_o(acc_valid),
        .acc_addr_o (acc_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '0;
            s1_addr_q <= '0;
        end else begin
            s1_q.valid   <= acc_valid;
            s1_q.lane_we <= lane_we;
            s1_q.wdata   <= wdata_i;
            s1_addr_q    <= acc_addr;
        end
    end

    assign s1_wr = s1_q.valid && (|s1_q.lane_we);
    assign s1_rd = s1_q.valid && !(|s1_q.lane_we);

    sbsram_lanes #(.DEPTH(DEPTH), .AW(AW)) u_lanes (
        .clk      (clk),
        .wr_i     (s1_wr),
        .lane_we_i(s1_q.lane_we),
        .addr_i   (s1_addr_q),
        .wdata_i  (s1_q.wdata),
        .rdata_o  (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            drv_q  <= 1'b0;
        end else begin
            drv_q <= s1_rd;
            if (s1_rd) dout_q <= rdata;
        end
    end

    assign dq_o    = dout_q;
    assign dq_oe_o = drv_q && !oe_n_i;

    // R1: reset leaves the output idle and cleared
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!drv_q && dout_q == '0));

    // R2: a captured read drives the output on the next edge
    a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
        s1_rd |=> drv_q);

    // R12: a captured write leaves the output undriven next edge
    a_r12_write_quiet: assert property (@(posedge clk) disable iff (rst)
        s1_wr |=> !drv_q);

    // R10: an unselected stage never drives
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !s1_q.valid |=> !drv_q);

    // R11: a high output enable always releases the driver
    a_r11_oe_release: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !dq_oe_o);

endmodule

// File: tb/sbsram_top_bench.sv
module sbsram_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          strb_n_i = 1'b1, adv_n_i = 1'b1;
    logic          cs_a_n_i = 1'b0, cs_b_i = 1'b1, cs_c_n_i = 1'b0;
    logic          gwr_n_i = 1'b1;
    logic [7:0]    bwe_n_i = 8'hFF;
    logic          ord_i = 1'b0;
    logic [63:0]   wdata_i = '0;
    logic          oe_n_i = 1'b0;
    logic [63:0]   dq_o;
    logic          dq_oe_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbsram_top #(.DEPTH(DEPTH)) u_sbsram_top (
        .clk(clk), .rst(rst), .addr_i(addr_i), .strb_n_i(strb_n_i),
        .adv_n_i(adv_n_i), .cs_a_n_i(cs_a_n_i), .cs_b_i(cs_b_i),
        .cs_c_n_i(cs_c_n_i), .gwr_n_i(gwr_n_i), .bwe_n_i(bwe_n_i),
        .ord_i(ord_i), .wdata_i(wdata_i), .oe_n_i(oe_n_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    // reference state
    logic [63:0]   mem_m [DEPTH];
    bit            sel_m = 0;
    logic [AW-1:0] base_m = '0;
    logic [1:0]    cnt_m = '0;
    bit            p_v [2];
    bit            p_drv [2];
    logic [63:0]   p_dat [2];
    string         p_req [2];

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b,
                                                input logic [1:0] c, input logic md);
        logic [1:0] lo;
        lo = md ? (b[1:0] ^ c) : (b[1:0] + c);
        return {b[AW-1:2], lo};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic sn, input logic an, input logic ea, input logic eb,
                       input logic ec, input logic gw, input logic [7:0] bw,
                       input logic [AW-1:0] a, input logic [63:0] wd, input logic md,
                       input logic oe, input string req);
        logic [7:0]    we;
        logic [AW-1:0] ea_addr;
        if (p_v[1]) begin
            chk(p_req[1], {63'd0, dq_oe_o}, {63'd0, p_drv[1] & !oe_n_i});
            if (p_drv[1]) chk(p_req[1], dq_o, p_dat[1]);
        end
        p_v[1] = p_v[0]; p_drv[1] = p_drv[0]; p_dat[1] = p_dat[0]; p_req[1] = p_req[0];
        strb_n_i = sn; adv_n_i = an; cs_a_n_i = ea; cs_b_i = eb; cs_c_n_i = ec;
        gwr_n_i = gw; bwe_n_i = bw; addr_i = a; wdata_i = wd; ord_i = md; oe_n_i = oe;
        @(posedge clk);
        if (!sn) begin
            sel_m = !ea && eb && !ec;
            if (sel_m) begin base_m = a; cnt_m = 2'd0; end
        end else if (!an && sel_m) begin
            cnt_m = cnt_m + 2'd1;
        end
        we = !gw ? 8'hFF : ~bw;
        ea_addr = beat_addr(base_m, cnt_m, md);
        p_v[0] = 1; p_req[0] = req; p_drv[0] = 0;
        if (sel_m) begin
            if (we == 8'h00) begin
                p_drv[0] = 1; p_dat[0] = mem_m[ea_addr];
            end else begin
                for (int k = 0; k < 8; k++)
                    if (we[k]) mem_m[ea_addr][k*8 +: 8] = wd[k*8 +: 8];
            end
        end
        @(negedge clk);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // shorthand: selected read cycle
    task automatic rd(input logic sn, input logic an, input logic [AW-1:0] a,
                      input logic md, input string req);
        cyc(sn, an, 0, 1, 0, 1, 8'hFF, a, rnd64(), md, 0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        p_v[0] = 0; p_v[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", {63'd0, dq_oe_o}, 64'd0);
        chk("R1", dq_o, 64'd0);

        // fill whole memory with global writes in linear bursts (R8, R12)
        for (int g = 0; g < DEPTH/4; g++) begin
            for (int b = 0; b < 4; b++)
                cyc(b != 0, b == 0, 0, 1, 0, 0, 8'($urandom()),
                    AW'(g*4), rnd64(), 0, 0, "R12");
        end

        // R3: linear burst from low bits 10 wraps within the group
        rd(0, 1, AW'(8'h16), 0, "R3");
        for (int b = 0; b < 3; b++) rd(1, 0, '0, 0, "R3");
        // R4: interleaved burst from low bits 11
        rd(0, 1, AW'(8'h27), 1, "R4");
        for (int b = 0; b < 3; b++) rd(1, 0, '0, 1, "R4");
        // R5: hold cycles repeat the same beat
        rd(0, 1, AW'(8'h31), 0, "R5");
        rd(1, 0, '0, 0, "R5");
        rd(1, 1, '0, 0, "R5");
        rd(1, 1, '0, 0, "R5");
        rd(1, 0, '0, 0, "R5");
        // R6: strobe wins over advance
        rd(0, 0, AW'(8'h42), 0, "R6");
        rd(0, 0, AW'(8'h43), 0, "R6");
        rd(1, 0, '0, 0, "R6");

        // R11: asynchronous output enable, output currently holds a read
        chk("R11", {63'd0, dq_oe_o}, 64'd1);
        oe_n_i = 1'b1; #1;
        chk("R11", {63'd0, dq_oe_o}, 64'd0);
        chk("R11", dq_o, p_dat[1]);
        oe_n_i = 1'b0; #1;
        chk("R11", {63'd0, dq_oe_o}, 64'd1);

        // R7: byte-lane writes then read back
        for (int t = 0; t < 8; t++) begin
            cyc(0, 1, 0, 1, 0, 1, ~(8'd1 << t), AW'(8'h50 + t), rnd64(), 0, 0, "R7");
            cyc(1, 1, 0, 1, 0, 1, 8'($urandom()), '0, rnd64(), 0, 0, "R7");
            rd(1, 1, '0, 0, "R7");
        end
        // R8: global write overrides lane enables
        cyc(0, 1, 0, 1, 0, 0, 8'hFF, AW'(8'h60), rnd64(), 0, 0, "R8");
        rd(1, 1, '0, 0, "R8");
        // R9: no enables -> read, contents unchanged
        cyc(0, 1, 0, 1, 0, 1, 8'hFF, AW'(8'h61), rnd64(), 0, 0, "R9");
        rd(1, 1, '0, 0, "R9");

        // R10: each chip enable alone deselects; writes and advances ignored
        for (int v = 0; v < 3; v++) begin
            cyc(0, 1, v == 0, v != 1, v == 2, 0, 8'h00, AW'(8'h70), rnd64(), 0, 0, "R10");
            cyc(1, 0, 0, 1, 0, 0, 8'h00, '0, rnd64(), 0, 0, "R10");
            cyc(1, 0, 0, 1, 0, 1, 8'hFF, '0, rnd64(), 0, 0, "R10");
        end
        rd(0, 1, AW'(8'h70), 0, "R10");
        for (int b = 0; b < 3; b++) rd(1, 0, '0, 0, "R10");

        // constrained random traffic (R2)
        begin
            logic md;
            md = 0;
            for (int i = 0; i < 3000; i++) begin
                logic sn, ea, eb, ec, gw;
                logic [7:0] bw;
                sn = ($urandom_range(5) != 0);
                ea = 0; eb = 1; ec = 0;
                if (!sn) begin
                    md = 1'($urandom());
                    ea = ($urandom_range(9) == 0);
                    eb = ($urandom_range(9) != 0);
                    ec = ($urandom_range(9) == 0);
                end
                gw = 1; bw = 8'hFF;
                if ($urandom_range(2) == 0) begin
                    if ($urandom_range(1) == 0) gw = 0;
                    else bw = 8'($urandom());
                end
                cyc(sn, 1'($urandom()), ea, eb, ec, gw, bw, AW'($urandom()),
                    rnd64(), md, ($urandom_range(7) == 0), "R2");
            end
        end
        // drain pipeline
        rd(1, 1, '0, 0, "R2");
        rd(1, 1, '0, 0, "R2");
        rd(1, 1, '0, 0, "R2");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule